// File: doc/BRIEF.md
# Configuration Intercept Register Handler

This block is application-side logic attached to the configuration-intercept port of a PCIe endpoint controller. When the controller exposes an intercepted configuration request, the handler raises a halt so the controller waits. It then decodes the request against a small vendor-specific extended-capability register window, applies any write locally, and answers through the override path. That answer is the merged register value for a write, or the stored register value for a read's completion.

The window begins at dword address 0x340 (byte address 0xD00) and runs to the top of the 10-bit dword address space. Its first dword is a fixed, read-only capability header. The next `NUM_REGS` dwords are writable registers, and each supported function number has its own bank of them. A request is accepted on the rising edge of the request strobe only. Because the strobe may stay high long after the halt is dropped, the handler waits to see it low before it takes another request.

Top module: `cfg_icpt_handler`

## Requirements
- R1: A request is accepted only when the strobe is sampled high at a clock edge after being sampled low at the previous edge. `halt_o` goes high in the cycle that follows that edge.
- R2: A strobe that stays high never starts a second request. A strobe that is already high when reset is released is ignored until it has been seen low.
- R3: `halt_o` stays high for exactly one cycle per accepted request (the decode cycle). In the next cycle `halt_o` is low and the override outputs carry the answer.
- R4: `ovr_en_o` and `ovr_data_o` hold their answer until the first clock edge in the response phase that samples the strobe low. At that edge both return to zero. `ovr_data_o` is zero whenever `ovr_en_o` is low.
- R5: Dword addresses below 0x340 are passed through: `ovr_en_o` stays low, `ovr_data_o` is zero, and no local register changes.
- R6: A read at 0x340 returns `CAP_HDR` (default 32'h1A10_000B). Reads at 0x341 through 0x340+`NUM_REGS` return that function's stored register. Every other dword in the window reads as zero. All window reads assert `ovr_en_o`.
- R7: A write to a register updates byte i (bits 8i+7:8i) from the write data only when byte-enable bit i is 1, and otherwise keeps the old byte. The merged value is presented on `ovr_data_o`.
- R8: A write with the poisoned bit set changes no register. The override carries the unchanged stored value.
- R9: Writes to the header, to unimplemented dwords, or from a function number not below `NUM_FUNCS` change nothing. The override shows the header or zero. Reads from an unsupported function number return zero.
- R10: Each supported function number has an independent register bank.
- R11: A synchronous active-low reset clears all registers and leaves `halt_o` and `ovr_en_o` low.
- R12: With `ENABLE` = 0, `halt_o` and `ovr_en_o` are held low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Intercepted-request strobe; other request fields are valid while high |
| wr_i | input | 1 | Request is a configuration write |
| addr_i | input | 10 | Dword register address |
| first_be_i | input | 4 | First-dword byte enables |
| poisoned_i | input | 1 | Poisoned bit from the request header |
| func_num_i | input | 3 | Target function number |
| wdata_i | input | 32 | Write payload, little-endian, first byte in [7:0] |
| halt_o | output | 1 | Holds off controller processing of the request |
| ovr_en_o | output | 1 | Override enable for write payload or read completion |
| ovr_data_o | output | 32 | Override data |

## Verification
Two functions meet in the same cycle. The response edge that drops `halt_o` and presents the override is also the edge at which a write is committed to the register file. So a write followed at once by a read of the same dword tests whether the read sees the committed value. The stimulus table pairs each write with a read of the same address, and it interleaves a poisoned write and writes from the other function in between. A second meeting point is the end of a response and the arrival of a new request. A one-cycle strobe pulse is provoked that ends before the response even starts. Separately, a strobe is held high across reset release. In both cases the bench judges that exactly one halt occurs per low-to-high transition of the strobe, and that the override outputs clear at the expected edge.

// File: rtl/cfg_icpt_pkg.sv
// Shared widths, window bounds and types for the configuration intercept
// register handler. Assumes a 10-bit dword address space whose top part
// is the vendor extended-capability window.
package cfg_icpt_pkg;

    localparam int CFG_ADDR_W = 10;
    localparam int CFG_DATA_W = 32;
    localparam int CFG_BE_W   = CFG_DATA_W / 8;
    localparam int CFG_FN_W   = 3;

    // First dword of the window; the window runs to the top of the space.
    localparam logic [CFG_ADDR_W-1:0] WIN_FIRST = 10'h340;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEC,
        ST_RESP
    } icpt_state_t;

    typedef struct packed {
        logic                  wr;
        logic [CFG_ADDR_W-1:0] addr;
        logic [CFG_BE_W-1:0]   be;
        logic                  poison;
        logic [CFG_FN_W-1:0]   func;
        logic [CFG_DATA_W-1:0] data;
    } icpt_req_t;

endpackage

// File: rtl/cfg_icpt_seq.sv
// Request sequencer. Detects the rising edge of the intercept strobe,
// captures the request, halts the controller for one decode cycle, then
// presents the register file's answer on the override outputs until the
// strobe is seen low. Assumes the request fields are valid in the cycle
// the strobe is first sampled high. With ENABLE = 0 all outputs are zero.
module cfg_icpt_seq
    import cfg_icpt_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  icpt_req_t             fields_i,
    input  logic                  hit_i,
    input  logic [CFG_DATA_W-1:0] result_i,
    output logic                  halt_o,
    output logic                  acc_stb_o,
    output icpt_req_t             cap_o,
    output logic                  ovr_en_o,
    output logic [CFG_DATA_W-1:0] ovr_data_o
);

    generate
        if (ENABLE) begin : g_on
            icpt_state_t           state_q;
            logic                  req_q;
            logic                  rise;
            logic                  halt_q;
            logic                  ovr_en_q;
            logic [CFG_DATA_W-1:0] ovr_data_q;
            icpt_req_t             cap_q;

            // Last sampled strobe; reset high so a strobe held over reset is not taken.
            always_ff @(posedge clk) begin
                if (!rst_n) req_q <= 1'b1;
                else        req_q <= req_i;
            end

            assign rise = req_i && !req_q;

            // Phase sequencing: idle, decode (halted), response (override held).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    state_q <= ST_IDLE;
                end else begin
                    case (state_q)
                        ST_IDLE: if (rise) state_q <= ST_DEC;
                        ST_DEC:  state_q <= ST_RESP;
                        ST_RESP: if (!req_i) state_q <= ST_IDLE;
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end

            // Halt is raised on an accepted edge and dropped after the decode cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)                          halt_q <= 1'b0;
                else if (state_q == ST_IDLE && rise) halt_q <= 1'b1;
                else if (state_q == ST_DEC)          halt_q <= 1'b0;
            end

            // Request fields are frozen at the accepted edge.
            always_ff @(posedge clk) begin
                if (!rst_n)                          cap_q <= '0;
                else if (state_q == ST_IDLE && rise) cap_q <= fields_i;
            end

            // Override answer is loaded after decode and cleared when the strobe falls.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ovr_en_q   <= 1'b0;
                    ovr_data_q <= '0;
                end else if (state_q == ST_DEC) begin
                    ovr_en_q   <= hit_i;
                    ovr_data_q <= hit_i ? result_i : '0;
                end else if (state_q == ST_RESP && !req_i) begin
                    ovr_en_q   <= 1'b0;
                    ovr_data_q <= '0;
                end
            end

            assign halt_o     = halt_q;
            assign acc_stb_o  = (state_q == ST_DEC);
            assign cap_o      = cap_q;
            assign ovr_en_o   = ovr_en_q;
            assign ovr_data_o = ovr_data_q;

            AST_HALT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                halt_q |=> !halt_q); // R3
            AST_OVR_AFTER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ovr_en_q) |-> $past(halt_q)); // R3
            AST_HALT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(halt_q) |-> $past(req_i)); // R1
            AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_RESP && req_i) |=> !halt_q); // R2
            AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                !ovr_en_q |-> (ovr_data_q == '0)); // R4
        end else begin : g_off
            assign halt_o     = 1'b0;
            assign acc_stb_o  = 1'b0;
            assign cap_o      = '0;
            assign ovr_en_o   = 1'b0;
            assign ovr_data_o = '0;
        end
    endgenerate

endmodule

// File: rtl/cfg_icpt_regs.sv
// Vendor capability register window. Decodes the captured request against
// the window, forms the read answer or the byte-merged write value, and
// commits writes on the access strobe. Assumes the captured request is
// stable during the strobe cycle. One bank of NUM_REGS registers per
// supported function; the header dword is a constant.
module cfg_icpt_regs
    import cfg_icpt_pkg::*;
#(
    parameter int                    NUM_FUNCS = 2,
    parameter int                    NUM_REGS  = 8,
    parameter logic [CFG_DATA_W-1:0] CAP_HDR   = 32'h1A10_000B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_stb_i,
    input  icpt_req_t             cap_i,
    output logic                  hit_o,
    output logic [CFG_DATA_W-1:0] result_o
);

    localparam int ENTRIES = NUM_FUNCS * NUM_REGS;

    logic [CFG_DATA_W-1:0] store [ENTRIES];
    logic [CFG_ADDR_W-1:0] offs;
    logic                  in_win;
    logic                  is_hdr;
    logic                  is_reg;
    logic                  fn_ok;
    logic                  slot_ok;
    int                    slot;
    logic [CFG_DATA_W-1:0] cur;
    logic [CFG_DATA_W-1:0] merged;
    logic                  wr_en;

    // Window decode: which dword kind the captured address selects.
    always_comb begin
        in_win  = (cap_i.addr >= WIN_FIRST);
        offs    = cap_i.addr - WIN_FIRST;
        is_hdr  = in_win && (offs == '0);
        is_reg  = in_win && (offs != '0) && (int'(offs) <= NUM_REGS);
        fn_ok   = int'(cap_i.func) < NUM_FUNCS;
        slot_ok = is_reg && fn_ok;
        slot    = int'(cap_i.func) * NUM_REGS + int'(offs) - 1;
    end

    // Current stored value of the selected register, zero if none.
    always_comb begin
        cur = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (slot_ok && k == slot) cur = store[k];
        end
    end

    // Byte-enable merge of the write payload over the stored value.
    for (genvar gb = 0; gb < CFG_BE_W; gb++) begin : g_byte
        assign merged[8*gb +: 8] = cap_i.be[gb] ? cap_i.data[8*gb +: 8] : cur[8*gb +: 8];
    end

    assign wr_en = acc_stb_i && cap_i.wr && !cap_i.poison && slot_ok;

    // Answer selection: header, merged write, stored value, or zero.
    always_comb begin
        if (!in_win)                      result_o = '0;
        else if (is_hdr)                  result_o = CAP_HDR;
        else if (!slot_ok)                result_o = '0;
        else if (cap_i.wr && !cap_i.poison) result_o = merged;
        else                              result_o = cur;
    end

    assign hit_o = in_win;

    for (genvar gk = 0; gk < ENTRIES; gk++) begin : g_entry
        // One register of one function bank; loads the merged value when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                    store[gk] <= '0;
            else if (wr_en && slot == gk)  store[gk] <= merged;
        end

        AST_POISON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_stb_i && cap_i.poison) |=> $stable(store[gk])); // R8
        AST_OUTSIDE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_stb_i && !in_win) |=> $stable(store[gk])); // R5
    end

endmodule

// File: rtl/cfg_icpt_handler.sv
// Top of the configuration intercept register handler. Bundles the request
// fields, runs them through the sequencer and serves them from the
// vendor capability register window. Assumes a single clock shared with
// the controller's intercept port and a synchronous active-low reset.
module cfg_icpt_handler
    import cfg_icpt_pkg::*;
#(
    parameter bit                    ENABLE    = 1'b1,
    parameter int                    NUM_FUNCS = 2,
    parameter int                    NUM_REGS  = 8,
    parameter logic [CFG_DATA_W-1:0] CAP_HDR   = 32'h1A10_000B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        wr_i,
    input  logic [9:0]  addr_i,
    input  logic [3:0]  first_be_i,
    input  logic        poisoned_i,
    input  logic [2:0]  func_num_i,
    input  logic [31:0] wdata_i,
    output logic        halt_o,
    output logic        ovr_en_o,
    output logic [31:0] ovr_data_o
);

    icpt_req_t             fields;
    icpt_req_t             cap;
    logic                  acc_stb;
    logic                  hit;
    logic [CFG_DATA_W-1:0] result;

    // Gather the request fields into one bundle.
    always_comb begin
        fields.wr     = wr_i;
        fields.addr   = addr_i;
        fields.be     = first_be_i;
        fields.poison = poisoned_i;
        fields.func   = func_num_i;
        fields.data   = wdata_i;
    end

    cfg_icpt_seq #(
        .ENABLE (ENABLE)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .fields_i   (fields),
        .hit_i      (hit),
        .result_i   (result),
        .halt_o     (halt_o),
        .acc_stb_o  (acc_stb),
        .cap_o      (cap),
        .ovr_en_o   (ovr_en_o),
        .ovr_data_o (ovr_data_o)
    );

    cfg_icpt_regs #(
        .NUM_FUNCS (NUM_FUNCS),
        .NUM_REGS  (NUM_REGS),
        .CAP_HDR   (CAP_HDR)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_stb_i (acc_stb),
        .cap_i     (cap),
        .hit_o     (hit),
        .result_o  (result)
    );

endmodule

// File: tb/test_cfg_icpt_handler.sv
module test_cfg_icpt_handler;

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [3:0]  be;
        logic        poison;
        logic [2:0]  fn;
        logic [31:0] wdata;
        logic        exp_en;
        logic [31:0] exp_data;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 10'h340, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'h1A10_000B, 4'd6},  // R6 header
        '{1'b0, 10'h341, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'h0,         4'd6},  // R6 reset value
        '{1'b1, 10'h341, 4'hF, 1'b0, 3'd0, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 4'd7},  // R7 full write
        '{1'b0, 10'h341, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'hDEAD_BEEF, 4'd7},  // R7 readback
        '{1'b1, 10'h341, 4'h5, 1'b0, 3'd0, 32'h1122_3344, 1'b1, 32'hDE22_BE44, 4'd7},  // R7 bytes 0,2
        '{1'b0, 10'h341, 4'hF, 1'b0, 3'd1, 32'h0,         1'b1, 32'h0,         4'd10}, // R10 other bank
        '{1'b1, 10'h348, 4'h8, 1'b0, 3'd1, 32'hA500_0000, 1'b1, 32'hA500_0000, 4'd7},  // R7 last reg
        '{1'b0, 10'h348, 4'hF, 1'b0, 3'd1, 32'h0,         1'b1, 32'hA500_0000, 4'd10}, // R10
        '{1'b1, 10'h341, 4'hF, 1'b1, 3'd0, 32'h0,         1'b1, 32'hDE22_BE44, 4'd8},  // R8 poisoned
        '{1'b0, 10'h341, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'hDE22_BE44, 4'd8},  // R8 kept
        '{1'b1, 10'h340, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'h1A10_000B, 4'd9},  // R9 header write
        '{1'b0, 10'h349, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'h0,         4'd6},  // R6 unimplemented
        '{1'b1, 10'h349, 4'hF, 1'b0, 3'd0, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd9},  // R9
        '{1'b0, 10'h3FF, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'h0,         4'd6},  // R6 top dword
        '{1'b0, 10'h33F, 4'hF, 1'b0, 3'd0, 32'h0,         1'b0, 32'h0,         4'd5},  // R5 below window
        '{1'b1, 10'h001, 4'hF, 1'b0, 3'd0, 32'h5555_5555, 1'b0, 32'h0,         4'd5},  // R5 write outside
        '{1'b0, 10'h341, 4'hF, 1'b0, 3'd5, 32'h0,         1'b1, 32'h0,         4'd9},  // R9 bad function
        '{1'b1, 10'h342, 4'hF, 1'b0, 3'd5, 32'h1234_5678, 1'b1, 32'h0,         4'd9},  // R9
        '{1'b0, 10'h342, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'h0,         4'd9},  // R9 untouched
        '{1'b0, 10'h341, 4'hF, 1'b0, 3'd0, 32'h0,         1'b1, 32'hDE22_BE44, 4'd5},  // R5 untouched
        '{1'b1, 10'h342, 4'h0, 1'b0, 3'd0, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd7}   // R7 no bytes
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [3:0]  be = '0;
    logic        poison = 1'b0;
    logic [2:0]  fn = '0;
    logic [31:0] wdata = '0;
    logic        halt, ovr_en, off_halt, off_en, off_seen = 1'b0;
    logic [31:0] ovr_data, off_data;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    cfg_icpt_handler i_cfg_icpt_handler (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .first_be_i(be), .poisoned_i(poison), .func_num_i(fn), .wdata_i(wdata),
        .halt_o(halt), .ovr_en_o(ovr_en), .ovr_data_o(ovr_data)
    );

    cfg_icpt_handler #(.ENABLE(1'b0)) i_cfg_icpt_handler_off (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .first_be_i(be), .poisoned_i(poison), .func_num_i(fn), .wdata_i(wdata),
        .halt_o(off_halt), .ovr_en_o(off_en), .ovr_data_o(off_data)
    );

    // R12 monitor: the disabled instance must never halt or override
    always @(posedge clk) if (off_halt || off_en) off_seen <= 1'b1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One full request; strobe held for hold extra cycles after the answer
    task automatic run_req(input vec_t v, input int hold);
        string t;
        t = $sformatf("R%0d", v.tag);
        @(negedge clk);
        req = 1'b1; wr = v.wr; addr = v.addr; be = v.be;
        poison = v.poison; fn = v.fn; wdata = v.wdata;
        @(negedge clk);
        chk("R1 halt after edge", {31'd0, halt}, 32'd1);
        @(negedge clk);
        chk("R3 halt dropped", {31'd0, halt}, 32'd0);
        chk({t, " ovr_en"}, {31'd0, ovr_en}, {31'd0, v.exp_en});
        chk({t, " ovr_data"}, ovr_data, v.exp_data);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R2 no retrigger", {31'd0, halt}, 32'd0);
            chk("R4 override held", ovr_data, v.exp_data);
        end
        req = 1'b0;
        @(negedge clk);
        chk("R4 override cleared", {31'd0, ovr_en}, 32'd0);
        chk("R4 data cleared", ovr_data, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        vec_t v;
        repeat (2) @(negedge clk);
        // R11: reset state
        chk("R11 halt in reset", {31'd0, halt}, 32'd0);
        chk("R11 ovr_en in reset", {31'd0, ovr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_req(VEC[i], (i % 3) + 1);

        // R11: registers cleared by reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 halt in reset", {31'd0, halt}, 32'd0);
        rst_n = 1'b1;
        v = '{1'b0, 10'h341, 4'hF, 1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 4'd11};
        run_req(v, 1);

        // R4: one-cycle strobe pulse ends before the response phase
        @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = 10'h340; fn = 3'd0;
        @(negedge clk);
        req = 1'b0;
        chk("R1 halt on short pulse", {31'd0, halt}, 32'd1);
        @(negedge clk);
        chk("R4 short pulse ovr_en", {31'd0, ovr_en}, 32'd1);
        chk("R4 short pulse data", ovr_data, 32'h1A10_000B);
        @(negedge clk);
        chk("R4 short pulse cleared", {31'd0, ovr_en}, 32'd0);

        // R2: strobe held high across reset release is ignored
        @(negedge clk); rst_n = 1'b0; req = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 held strobe ignored", {30'd0, halt, ovr_en}, 32'd0);
        end
        req = 1'b0;
        v = '{1'b0, 10'h340, 4'hF, 1'b0, 3'd1, 32'h0, 1'b1, 32'h1A10_000B, 4'd2};
        run_req(v, 2);

        chk("R12 disabled instance quiet", {31'd0, off_seen}, 32'd0);
        summary();
    end

endmodule